// File: doc/BRIEF.md
# Register-Driven Serial Flash Command Engine

This block is a small SPI master for short serial-flash commands. A host fills a bank of byte registers (an opcode, up to three address bytes and one payload byte) and then writes a control byte. That control byte starts the transfer and selects three things: how many bytes go out, how many bytes come back, and which of two serial clock rates is used. The engine drives chip select, SCK and MOSI, and samples MISO. It places up to three returned bytes back into the register bank, where the host reads them.

The outgoing length is not a plain count. A 2-bit code selects one of four frame shapes: opcode only, opcode plus payload, opcode plus three address bytes, or opcode plus address plus payload. The address bytes sit in the bank in the reverse of their wire order, so the highest offset of the three is shifted out first. A busy flag in bit 7 of offset 0 covers the whole transfer. The engine ignores control writes while that flag is set.

The two SCK rates come from the system clock, divided by the even parameters `SLOW_DIV` and `FAST_DIV`.

Top module: `spi_cmd_engine`

## Requirements
- R1: After reset, `spi_cs_n` is 1, `spi_sck` is 0, `spi_mosi` is 0, and every offset 0 to 7 reads 0x00.
- R2: Offset 0 reads as {busy, 7'b0}. Bit 7 is 1 from the cycle after an accepted start until chip select is released.
- R3: A write to offset 0 whose bits 7:4 equal 4 starts a transfer with an SCK period of `SLOW_DIV` clocks. Bits 7:4 equal to 5 start one with an SCK period of `FAST_DIV` clocks. Any other value in bits 7:4 starts nothing.
- R4: Control bits 1:0 set the outgoing byte count: code 0 sends 1 byte, code 1 sends 2, code 2 sends 4, code 3 sends 5. Control bits 3:2 set the returned byte count, 0 to 3. One transfer gives exactly 8 x (out + in) SCK pulses.
- R5: The first byte on the wire is always offset 1. With code 1 it is followed by offset 7. With code 2 it is followed by offsets 4, 3, 2. With code 3 it is followed by offsets 4, 3, 2, 7.
- R6: Returned bytes are written to offsets 5, 6 and 7 in arrival order. An offset that no returned byte reaches keeps its value.
- R7: The link uses SPI mode 0 with MSB first. SCK is low whenever chip select is high. MOSI changes only while SCK is low. MOSI is 0 during the read phase.
- R8: Chip select falls on the clock edge that accepts a start. It stays low for (8 x (out + in) + 1) SCK periods, which leaves one full SCK period after the last bit. Busy clears on the same edge at which chip select rises.
- R9: A control write arriving while busy is set is ignored. This includes a write sampled on the very edge at which chip select is released.
- R10: Offsets 1 to 7 read back the last value written. When a returned byte and a host write target the same offset in the same cycle, the returned byte is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset for write and read |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational from `reg_addr`) |
| spi_cs_n | output | 1 | Flash chip select, active low |
| spi_sck | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |

## Verification
Two pairs of events can fall in the same cycle.

The first pair is the storing of a returned byte and a host write to the same offset. The bench computes the exact edge at which the last bit of the first returned byte completes, which is 8 x (out + 1) SCK periods after the start. It places a host write to offset 5 on that edge and expects the flash byte to survive.

The second pair is the release of chip select and a new control write. The bench samples a valid start on the release edge itself. It then confirms that chip select stays high and busy stays clear afterwards.

// File: rtl/spi_cmd_pkg.sv
`timescale 1ns/1ps
package spi_cmd_pkg;

    localparam int REG_W    = 8;
    localparam int ADDR_W   = 3;
    localparam int NUM_REGS = 1 << ADDR_W;
    localparam int MAX_OUT  = 5;
    localparam int MAX_IN   = 3;
    localparam int FRAME_W  = MAX_OUT * REG_W;
    localparam int BIT_W    = $clog2((MAX_OUT + MAX_IN) * REG_W);

    // register offsets the engine relies on
    localparam logic [ADDR_W-1:0] OFF_CTL   = 3'd0;
    localparam logic [ADDR_W-1:0] OFF_OPC   = 3'd1;
    localparam logic [ADDR_W-1:0] OFF_ADR_L = 3'd2;
    localparam logic [ADDR_W-1:0] OFF_ADR_M = 3'd3;
    localparam logic [ADDR_W-1:0] OFF_ADR_H = 3'd4;
    localparam logic [ADDR_W-1:0] OFF_RX0   = 3'd5;
    localparam logic [ADDR_W-1:0] OFF_PAY   = 3'd7;

    localparam logic [3:0] KIND_SLOW = 4'h4;
    localparam logic [3:0] KIND_FAST = 4'h5;

    typedef struct packed {
        logic [3:0] kind;
        logic [1:0] rd_cnt;
        logic [1:0] wr_code;
    } ctl_t;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_SHIFT,
        PH_TAIL
    } phase_e;

    // outgoing byte count for a write-length code
    function automatic logic [2:0] wr_len(input logic [1:0] code);
        case (code)
            2'd0:    return 3'd1;
            2'd1:    return 3'd2;
            2'd2:    return 3'd4;
            default: return 3'd5;
        endcase
    endfunction

endpackage

// File: rtl/spi_cmd_regs.sv
`timescale 1ns/1ps
module spi_cmd_regs
    import spi_cmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  wdata,
    input  logic              rx_we,
    input  logic [1:0]        rx_idx,
    input  logic [REG_W-1:0]  rx_byte,
    input  logic              busy,
    output logic [REG_W-1:0]  rdata,
    output logic [REG_W-1:0]  opc,
    output logic [REG_W-1:0]  adr_h,
    output logic [REG_W-1:0]  adr_m,
    output logic [REG_W-1:0]  adr_l,
    output logic [REG_W-1:0]  pay
);

    logic [NUM_REGS-1:0][REG_W-1:0] bank;
    logic [ADDR_W-1:0]              rx_off;

    assign rx_off = OFF_RX0 + {1'b0, rx_idx};

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_byte
        if (i == 0) begin : g_stat
            assign bank[i] = {busy, {(REG_W-1){1'b0}}};
        end else begin : g_data
            logic [REG_W-1:0] q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    q <= '0;
                end else if (rx_we && rx_off == ADDR_W'(i)) begin
                    q <= rx_byte;      // returned data has priority
                end else if (wr_en && addr == ADDR_W'(i)) begin
                    q <= wdata;
                end
            end
            assign bank[i] = q;
        end
    end

    assign rdata = bank[addr];
    assign opc   = bank[OFF_OPC];
    assign adr_h = bank[OFF_ADR_H];
    assign adr_m = bank[OFF_ADR_M];
    assign adr_l = bank[OFF_ADR_L];
    assign pay   = bank[OFF_PAY];

endmodule

// File: rtl/spi_cmd_frame.sv
`timescale 1ns/1ps
module spi_cmd_frame
    import spi_cmd_pkg::*;
(
    input  logic [REG_W-1:0]   opc,
    input  logic [REG_W-1:0]   adr_h,
    input  logic [REG_W-1:0]   adr_m,
    input  logic [REG_W-1:0]   adr_l,
    input  logic [REG_W-1:0]   pay,
    input  logic [1:0]         wr_code,
    input  logic [1:0]         rd_cnt,
    output logic [FRAME_W-1:0] frame,
    output logic [BIT_W-1:0]   wr_bits,
    output logic [BIT_W-1:0]   tot_bits
);

    logic [2:0] nout;
    logic [3:0] nall;

    assign nout     = wr_len(wr_code);
    assign nall     = {1'b0, nout} + {2'b00, rd_cnt};
    assign wr_bits  = {1'b0, nout, 3'b000};
    assign tot_bits = {nall, 3'b000};

    // frame is left-aligned: bit FRAME_W-1 goes on the wire first
    always_comb begin
        case (wr_code)
            2'd0:    frame = {opc, {(4*REG_W){1'b0}}};
            2'd1:    frame = {opc, pay, {(3*REG_W){1'b0}}};
            2'd2:    frame = {opc, adr_h, adr_m, adr_l, {REG_W{1'b0}}};
            default: frame = {opc, adr_h, adr_m, adr_l, pay};
        endcase
    end

endmodule

// File: rtl/spi_cmd_serial.sv
`timescale 1ns/1ps
module spi_cmd_serial
    import spi_cmd_pkg::*;
#(
    parameter int SLOW_DIV = 6,
    parameter int FAST_DIV = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic               use_fast,
    input  logic [FRAME_W-1:0] frame,
    input  logic [BIT_W-1:0]   wr_bits,
    input  logic [BIT_W-1:0]   tot_bits,
    input  logic               miso,
    output logic               cs_n,
    output logic               sck,
    output logic               mosi,
    output logic               busy,
    output logic               rx_we,
    output logic [1:0]         rx_idx,
    output logic [REG_W-1:0]   rx_byte
);

    localparam int CNT_W = $clog2(SLOW_DIV + 1);
    localparam logic [CNT_W-1:0] SLOW_LIM = CNT_W'(SLOW_DIV / 2 - 1);
    localparam logic [CNT_W-1:0] FAST_LIM = CNT_W'(FAST_DIV / 2 - 1);

    phase_e             ph_q;
    logic [CNT_W-1:0]   cnt_q;
    logic [CNT_W-1:0]   lim_q;
    logic [CNT_W-1:0]   tail_lim;
    logic               sck_q;
    logic               cs_n_q;
    logic               busy_q;
    logic [FRAME_W-1:0] tx_q;
    logic [BIT_W-1:0]   bit_q;
    logic [BIT_W-1:0]   last_q;
    logic [BIT_W-1:0]   wb_q;
    logic [REG_W-1:0]   rx_sh;
    logic               half_end;
    logic               fall_now;

    assign half_end = (cnt_q == lim_q);
    assign tail_lim = {lim_q[CNT_W-2:0], 1'b1};   // two half periods minus one
    assign fall_now = (ph_q == PH_SHIFT) && half_end && sck_q;

    assign rx_we   = fall_now && (bit_q[2:0] == 3'd7) && (bit_q >= wb_q);
    assign rx_idx  = 2'((bit_q - wb_q) >> 3);
    assign rx_byte = rx_sh;

    assign cs_n = cs_n_q;
    assign sck  = sck_q;
    assign busy = busy_q;
    assign mosi = tx_q[FRAME_W-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q   <= PH_IDLE;
            cnt_q  <= '0;
            lim_q  <= SLOW_LIM;
            sck_q  <= 1'b0;
            cs_n_q <= 1'b1;
            busy_q <= 1'b0;
            tx_q   <= '0;
            bit_q  <= '0;
            last_q <= '0;
            wb_q   <= '0;
            rx_sh  <= '0;
        end else begin
            case (ph_q)
                PH_IDLE: begin
                    if (start) begin
                        ph_q   <= PH_SHIFT;
                        cnt_q  <= '0;
                        lim_q  <= use_fast ? FAST_LIM : SLOW_LIM;
                        cs_n_q <= 1'b0;
                        busy_q <= 1'b1;
                        sck_q  <= 1'b0;
                        tx_q   <= frame;
                        bit_q  <= '0;
                        last_q <= tot_bits - 1'b1;
                        wb_q   <= wr_bits;
                    end
                end
                PH_SHIFT: begin
                    if (half_end) begin
                        cnt_q <= '0;
                        if (!sck_q) begin
                            sck_q <= 1'b1;
                            rx_sh <= {rx_sh[REG_W-2:0], miso};
                        end else begin
                            sck_q <= 1'b0;
                            tx_q  <= {tx_q[FRAME_W-2:0], 1'b0};
                            if (bit_q == last_q) begin
                                ph_q <= PH_TAIL;
                            end else begin
                                bit_q <= bit_q + 1'b1;
                            end
                        end
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                PH_TAIL: begin
                    if (cnt_q == tail_lim) begin
                        ph_q   <= PH_IDLE;
                        cnt_q  <= '0;
                        cs_n_q <= 1'b1;
                        busy_q <= 1'b0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: ph_q <= PH_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/spi_cmd_engine.sv
`timescale 1ns/1ps
module spi_cmd_engine
    import spi_cmd_pkg::*;
#(
    parameter int SLOW_DIV = 6,
    parameter int FAST_DIV = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    output logic              spi_cs_n,
    output logic              spi_sck,
    output logic              spi_mosi,
    input  logic              spi_miso
);

    ctl_t               ctl;
    logic               busy;
    logic               go;
    logic               rx_we;
    logic [1:0]         rx_idx;
    logic [REG_W-1:0]   rx_byte;
    logic [REG_W-1:0]   opc, adr_h, adr_m, adr_l, pay;
    logic [FRAME_W-1:0] frame;
    logic [BIT_W-1:0]   wr_bits, tot_bits;

    assign ctl = ctl_t'(reg_wdata);
    assign go  = reg_wr && (reg_addr == OFF_CTL) && !busy &&
                 (ctl.kind == KIND_SLOW || ctl.kind == KIND_FAST);

    spi_cmd_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (reg_wr),
        .addr    (reg_addr),
        .wdata   (reg_wdata),
        .rx_we   (rx_we),
        .rx_idx  (rx_idx),
        .rx_byte (rx_byte),
        .busy    (busy),
        .rdata   (reg_rdata),
        .opc     (opc),
        .adr_h   (adr_h),
        .adr_m   (adr_m),
        .adr_l   (adr_l),
        .pay     (pay)
    );

    spi_cmd_frame u_frame (
        .opc      (opc),
        .adr_h    (adr_h),
        .adr_m    (adr_m),
        .adr_l    (adr_l),
        .pay      (pay),
        .wr_code  (ctl.wr_code),
        .rd_cnt   (ctl.rd_cnt),
        .frame    (frame),
        .wr_bits  (wr_bits),
        .tot_bits (tot_bits)
    );

    spi_cmd_serial #(
        .SLOW_DIV (SLOW_DIV),
        .FAST_DIV (FAST_DIV)
    ) u_serial (
        .clk      (clk),
        .rst      (rst),
        .start    (go),
        .use_fast (ctl.kind == KIND_FAST),
        .frame    (frame),
        .wr_bits  (wr_bits),
        .tot_bits (tot_bits),
        .miso     (spi_miso),
        .cs_n     (spi_cs_n),
        .sck      (spi_sck),
        .mosi     (spi_mosi),
        .busy     (busy),
        .rx_we    (rx_we),
        .rx_idx   (rx_idx),
        .rx_byte  (rx_byte)
    );

endmodule

// File: rtl/spi_cmd_engine_chk.sv
`timescale 1ns/1ps
module spi_cmd_engine_chk
    import spi_cmd_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [REG_W-1:0]  reg_wdata,
    input logic              spi_cs_n,
    input logic              spi_sck,
    input logic              spi_mosi,
    input logic              busy
);

    AST_SCK_IDLE_LOW: assert property (@(posedge clk) disable iff (rst)
        spi_cs_n |-> !spi_sck);                                        // R7

    AST_MOSI_HOLD_HIGH: assert property (@(posedge clk) disable iff (rst)
        (spi_sck && $past(spi_sck)) |-> $stable(spi_mosi));            // R7

    AST_BUSY_TRACKS_CS: assert property (@(posedge clk) disable iff (rst)
        busy == !spi_cs_n);                                            // R8

    AST_RELEASE_SCK_LOW: assert property (@(posedge clk) disable iff (rst)
        $rose(spi_cs_n) |-> $past(!spi_sck));                          // R8

    AST_START_LEGAL: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(reg_wr && reg_addr == OFF_CTL &&
            (reg_wdata[7:4] == KIND_SLOW || reg_wdata[7:4] == KIND_FAST))); // R3

endmodule

bind spi_cmd_engine spi_cmd_engine_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .spi_cs_n  (spi_cs_n),
    .spi_sck   (spi_sck),
    .spi_mosi  (spi_mosi),
    .busy      (busy)
);

// File: tb/spi_cmd_engine_bench.sv
`timescale 1ns/1ps
module spi_cmd_engine_bench;

    localparam int SLOW_DIV = 6;
    localparam int FAST_DIV = 4;
    localparam logic [63:0] STREAM = 64'hA5C3_3C96_E1F0_0F5A;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       reg_wr = 1'b0;
    logic [2:0] reg_addr = 3'd0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       spi_cs_n, spi_sck, spi_mosi;
    logic       spi_miso = 1'b0;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    int sbit = 0;
    int nseen = 0;
    int t_r1 = -1;
    int t_r2 = -1;
    int mode_err = 0;
    logic [63:0] mosi_log = '0;

    spi_cmd_engine #(.SLOW_DIV(SLOW_DIV), .FAST_DIV(FAST_DIV)) u_spi_cmd_engine (
        .clk       (clk),
        .rst       (rst),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .spi_cs_n  (spi_cs_n),
        .spi_sck   (spi_sck),
        .spi_mosi  (spi_mosi),
        .spi_miso  (spi_miso)
    );

    always #10 clk = ~clk;   // 50 MHz
    always @(negedge clk) cyc++;

    // flash model: returns STREAM bit by bit, logs MOSI on rising SCK
    always @(negedge spi_cs_n) begin
        sbit = 0;
        spi_miso = STREAM[63];
    end
    always @(posedge spi_sck) begin
        mosi_log = {mosi_log[62:0], spi_mosi};
        nseen++;
        if (t_r1 < 0) t_r1 = cyc;
        else if (t_r2 < 0) t_r2 = cyc;
    end
    always @(negedge spi_sck) begin
        if (!spi_cs_n) begin
            sbit++;
            if (sbit < 64) spi_miso = STREAM[63 - sbit];
        end
    end
    always @(spi_mosi) if (spi_sck === 1'b1) mode_err++;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk);
        @(negedge clk);
        reg_wr = 1'b0; reg_addr = 3'd0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
        reg_addr = 3'd0;
    endtask

    function automatic int out_len(input logic [1:0] c);
        case (c)
            2'd0: return 1;
            2'd1: return 2;
            2'd2: return 4;
            default: return 5;
        endcase
    endfunction

    function automatic logic [7:0] stream_byte(input int k);
        return STREAM[63 - 8*k -: 8];
    endfunction

    // start a transfer, optionally inject one host write sampled at edge E0+side_k,
    // and check timing, pulse count, wire contents and mode
    task automatic run_xfer(input logic [7:0] ctl, input logic [39:0] exp_tx, input int side_k,
                            input logic [2:0] side_a, input logic [7:0] side_d);
        int wb, rb, half, nbits, total;
        logic [63:0] aligned;
        wb = out_len(ctl[1:0]);
        rb = int'(ctl[3:2]);
        half = (ctl[7:4] == 4'h5) ? FAST_DIV/2 : SLOW_DIV/2;
        nbits = 8 * (wb + rb);
        total = (nbits + 1) * 2 * half;
        nseen = 0; t_r1 = -1; t_r2 = -1; mode_err = 0; mosi_log = '0;
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 3'd0; reg_wdata = ctl;
        @(posedge clk);
        for (int c = 1; c <= total; c++) begin
            @(negedge clk);
            reg_wr = 1'b0; reg_addr = 3'd0;
            #1;
            if (c == 1)
                chk(reg_rdata == 8'h80 && !spi_cs_n, "R2 busy after start", {56'd0, reg_rdata}, 64'h80);
            if (c == total)
                chk(reg_rdata == 8'h80 && !spi_cs_n, "R8 cs low until release edge", {63'd0, spi_cs_n}, 64'd0);
            if (c == side_k) begin
                reg_wr = 1'b1; reg_addr = side_a; reg_wdata = side_d;
            end
            @(posedge clk);
        end
        @(negedge clk);
        reg_wr = 1'b0; reg_addr = 3'd0;
        #1;
        chk(reg_rdata == 8'h00 && spi_cs_n, "R8 busy and cs release together", {55'd0, spi_cs_n, reg_rdata}, 64'h100);
        chk(nseen == nbits, "R4 SCK pulse count", 64'(nseen), 64'(nbits));
        chk((t_r2 - t_r1) == 2*half, "R3 SCK period", 64'(t_r2 - t_r1), 64'(2*half));
        aligned = mosi_log << (64 - nbits);
        chk(aligned == {exp_tx, 24'd0}, "R5 wire order", aligned, {exp_tx, 24'd0});
        chk(mode_err == 0, "R7 MOSI moved while SCK high", 64'(mode_err), 64'd0);
    endtask

    task automatic t_reset();
        logic [7:0] d;
        chk(spi_cs_n && !spi_sck && !spi_mosi, "R1 pins at reset", {61'd0, spi_cs_n, spi_sck, spi_mosi}, 64'h4);
        for (int a = 0; a < 8; a++) begin
            rd(3'(a), d);
            chk(d == 8'h00, "R1 register at reset", {56'd0, d}, 64'd0);
        end
    endtask

    task automatic t_regs();
        logic [7:0] d;
        wr(3'd1, 8'h9F); wr(3'd2, 8'h11); wr(3'd3, 8'h22); wr(3'd4, 8'h33);
        wr(3'd5, 8'h44); wr(3'd6, 8'h55); wr(3'd7, 8'h66);
        for (int a = 1; a < 8; a++) begin
            rd(3'(a), d);
            chk(d == ((a == 1) ? 8'h9F : 8'((a - 1) * 8'h11)), "R10 readback", {56'd0, d},
                {56'd0, (a == 1) ? 8'h9F : 8'((a - 1) * 8'h11)});
        end
        rd(3'd0, d);
        chk(d == 8'h00, "R2 idle status", {56'd0, d}, 64'd0);
    endtask

    task automatic t_op_read3();   // code 0, three bytes back, slow
        logic [7:0] d;
        run_xfer(8'h4C, {8'h9F, 32'd0}, 0, 3'd0, 8'h00);
        for (int k = 0; k < 3; k++) begin
            rd(3'(5 + k), d);
            chk(d == stream_byte(1 + k), "R6 returned byte order", {56'd0, d}, {56'd0, stream_byte(1 + k)});
        end
    endtask

    task automatic t_op_pay();     // code 1, nothing back, fast
        logic [7:0] d;
        wr(3'd7, 8'h66);
        run_xfer(8'h51, {8'h9F, 8'h66, 24'd0}, 0, 3'd0, 8'h00);
        rd(3'd5, d);
        chk(d == stream_byte(1), "R6 offset 5 untouched", {56'd0, d}, {56'd0, stream_byte(1)});
        rd(3'd7, d);
        chk(d == 8'h66, "R6 offset 7 untouched", {56'd0, d}, 64'h66);
    endtask

    task automatic t_op_addr_read1();  // code 2, one byte back, fast
        logic [7:0] d;
        run_xfer(8'h56, {8'h9F, 8'h33, 8'h22, 8'h11, 8'h00}, 0, 3'd0, 8'h00);
        rd(3'd5, d);
        chk(d == stream_byte(4), "R6 first returned byte", {56'd0, d}, {56'd0, stream_byte(4)});
        rd(3'd6, d);
        chk(d == stream_byte(2), "R6 offset 6 untouched", {56'd0, d}, {56'd0, stream_byte(2)});
    endtask

    task automatic t_op_addr_pay();    // code 3, slow
        run_xfer(8'h43, {8'h9F, 8'h33, 8'h22, 8'h11, 8'h66}, 0, 3'd0, 8'h00);
    endtask

    task automatic t_bad_kind();
        wr(3'd0, 8'h63);
        wr(3'd0, 8'h0F);
        repeat (6) begin
            @(negedge clk);
            #1 chk(spi_cs_n && reg_rdata == 8'h00, "R3 invalid kind ignored", {55'd0, spi_cs_n, reg_rdata}, 64'h100);
        end
    endtask

    task automatic t_busy_ignore();
        int total2;
        // restart attempt mid-transfer: timing of the first transfer must be unchanged
        run_xfer(8'h4C, {8'h9F, 32'd0}, 10, 3'd0, 8'h53);
        // start attempt sampled on the release edge
        total2 = (8 + 1) * 2 * (SLOW_DIV/2);
        run_xfer(8'h40, {8'h9F, 32'd0}, total2, 3'd0, 8'h51);
        repeat (8) begin
            @(negedge clk);
            #1 chk(spi_cs_n && reg_rdata == 8'h00, "R9 write on release edge ignored", {55'd0, spi_cs_n, reg_rdata}, 64'h100);
        end
    endtask

    task automatic t_collide();   // code 0, one byte back, fast
        logic [7:0] d;
        int k;
        wr(3'd5, 8'h00);
        k = (1 + 1) * 8 * FAST_DIV;   // falling edge of last bit of first returned byte
        run_xfer(8'h54, {8'h9F, 32'd0}, k, 3'd5, 8'hEE);
        rd(3'd5, d);
        chk(d == stream_byte(1), "R10 returned byte wins over host write", {56'd0, d}, {56'd0, stream_byte(1)});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog R8 actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        #1;
        t_reset();
        t_regs();
        t_op_read3();
        t_op_pay();
        t_op_addr_read1();
        t_op_addr_pay();
        t_bad_kind();
        t_busy_ignore();
        t_collide();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule